// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Inserter

This block sits in the transmit path between a frame buffer and the MAC serialiser. It takes one outgoing Ethernet frame at a time as a byte stream. The stream starts at the destination address and carries no preamble. Each byte comes with start and end markers on a valid/ready handshake. The block passes the bytes through in order. Under a 3-bit pad selector and a CRC-enable control, it zero-pads short frames up to a minimum body length and appends a CRC-32 frame check sequence.

Some options act on each frame. A 4-byte leading header can be kept out of the CRC. Frames carrying the VLAN type value 8100h can be padded to the longer minimum. Frames that grow past a programmable length limit are cut short and flagged. When no CRC is appended, the last four bytes supplied are checked as an FCS. One cycle after each frame leaves the block, a status word reports the byte count sent, a CRC-error flag, an abort flag and a VLAN flag. All configuration inputs must be held steady while a frame is in flight.

Top module: `eth_tx_padfcs`

## Requirements
- R1: Every accepted frame byte appears on the output in order. `out_sof` is set on the first byte and `out_eof` on the last. An output byte and its markers stay unchanged while `out_valid` is high and `out_ready` is low. After reset, `out_valid` and `stat_valid` are low and `in_ready` is high.
- R2: With `cfg_crc_en`=1 and `cfg_pad` equal to 3'b011 or 3'b111, a frame body shorter than MIN_LONG (64) bytes gets zero bytes appended until the body is 64 bytes long. The body is the bytes after any header, up to the end of the payload, with the FCS not counted.
- R3: With `cfg_crc_en`=1 and `cfg_pad`=3'b001, a body shorter than MIN_SHORT (60) bytes is zero-padded to 60. A body that already has 60 or more bytes gets no padding.
- R4: With `cfg_crc_en`=1 and `cfg_pad`=3'b101, the pad target is 64 if body bytes 12 and 13 are 0x81 and 0x00, and 60 otherwise. `stat_vlan` reports that match for every frame.
- R5: When `cfg_pad` bit 0 is 0 (codes 000, 010, 100, 110), no pad bytes are inserted.
- R6: With `cfg_crc_en`=1, four FCS bytes follow the body, including any pad, and the last FCS byte carries `out_eof`. The FCS is CRC-32 with polynomial 04C11DB7h, processed bit-reflected from an all-ones start and complemented at the end. The bytes are sent least significant first, and the CRC covers the pad bytes.
- R7: With `cfg_crc_en`=0, no pad and no FCS are added, whatever `cfg_pad` holds. The last four body bytes are checked as an FCS of the bytes before them, and a mismatch sets `stat_crc_err`. `stat_crc_err` is always 0 when `cfg_crc_en`=1.
- R8: With `cfg_hdr_en`=1, the first 4 bytes of a frame are forwarded but left out of the CRC, the CRC check, the pad count and the length limit.
- R9: With `cfg_huge_en`=0, the byte that takes the body past `cfg_max_len` is forwarded with `out_eof` and `out_abort` set. The rest of that input frame is consumed and dropped, no pad or FCS follows, and `stat_abort` is set. With `cfg_huge_en`=1, no frame is aborted.
- R10: `in_ready` is low while pad or FCS bytes are being emitted. Bytes that arrive between frames without `in_sof` are accepted and discarded.
- R11: `stat_valid` pulses for exactly one cycle, in the cycle after the `out_eof` byte is handshaken. `stat_len` then holds the total number of bytes sent for that frame, including header, pad and FCS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pad | input | 3 | Pad selector |
| cfg_crc_en | input | 1 | Append FCS (also enables padding) |
| cfg_hdr_en | input | 1 | First 4 bytes are a header outside the CRC |
| cfg_huge_en | input | 1 | Disable the length limit |
| cfg_max_len | input | LEN_W | Largest body length allowed |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle if valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_abort | output | 1 | Frame cut short by the length limit (with out_eof) |
| stat_valid | output | 1 | Status word valid (one cycle) |
| stat_len | output | LEN_W | Bytes sent for the frame |
| stat_crc_err | output | 1 | Supplied FCS did not match |
| stat_abort | output | 1 | Frame was aborted |
| stat_vlan | output | 1 | VLAN type value detected |

## Verification
The bench uses the default parameters: LEN_W of 16, minimum lengths of 60 and 64, a 4-byte header and the type field at body offset 12. It reaches the length limit by driving `cfg_max_len` down to 70 at run time, so the abort boundary is exercised one byte either side without long frames. Because the 60/64 defaults hold, a 20-byte body tests every pad target. Randomised `out_ready` stalls keep the output register in its hold state through pad and FCS emission.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_DROP
  } tx_state_e;

  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
  // register value left after a body plus its own correct FCS has been run through
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q,
  output logic [31:0] crc_nxt
);

  logic [31:0] base;

  always_comb begin
    base    = clr ? CRC_INIT : crc_q;
    crc_nxt = crc32_step(base, din);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_INIT;
    end else if (en) begin
      crc_q <= crc_nxt;
    end else if (clr) begin
      crc_q <= CRC_INIT;
    end
  end

endmodule

// File: rtl/eth_tx_track.sv
module eth_tx_track #(
  parameter int LEN_W     = 16,
  parameter int HDR_BYTES = 4,
  parameter int VLAN_POS  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic             step,
  input  logic             pad_step,
  input  logic [7:0]       din,
  input  logic             hdr_en,
  output logic             is_hdr,
  output logic [LEN_W-1:0] body_after,
  output logic [LEN_W-1:0] body_q,
  output logic             vlan_now
);

  localparam logic [LEN_W-1:0] HOFF    = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] POS_HI  = LEN_W'(VLAN_POS);
  localparam logic [LEN_W-1:0] POS_LO  = LEN_W'(VLAN_POS + 1);
  localparam logic [7:0]       TYPE_HI = 8'h81;
  localparam logic [7:0]       TYPE_LO = 8'h00;

  logic [LEN_W-1:0] pos_q, pos_cur, hoff, body_idx, body_base;
  logic             hi_q, vlan_q, hi_base, vl_base;

  always_comb begin
    pos_cur    = first ? '0 : pos_q;
    hoff       = hdr_en ? HOFF : '0;
    is_hdr     = pos_cur < hoff;
    body_idx   = pos_cur - hoff;
    body_base  = first ? '0 : body_q;
    body_after = body_base + (is_hdr ? '0 : LEN_W'(1));
    hi_base    = first ? 1'b0 : hi_q;
    vl_base    = first ? 1'b0 : vlan_q;
    vlan_now   = vl_base ||
                 (step && !is_hdr && (body_idx == POS_LO) && hi_base && (din == TYPE_LO));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      body_q <= '0;
      hi_q   <= 1'b0;
      vlan_q <= 1'b0;
    end else if (step) begin
      pos_q  <= pos_cur + LEN_W'(1);
      body_q <= body_after;
      hi_q   <= (!is_hdr && (body_idx == POS_HI)) ? (din == TYPE_HI) : hi_base;
      vlan_q <= vlan_now;
    end else if (pad_step) begin
      body_q <= body_q + LEN_W'(1);
    end
  end

endmodule

// File: rtl/eth_tx_outreg.sv
module eth_tx_outreg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] ld_data,
  input  logic       ld_sof,
  input  logic       ld_eof,
  input  logic       ld_abort,
  input  logic       out_ready,
  output logic       free,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_abort
);

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_sof   <= ld_sof;
      out_eof   <= ld_eof;
      out_abort <= ld_abort;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/eth_tx_padfcs.sv
module eth_tx_padfcs
  import eth_tx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MIN_SHORT = 60,
  parameter int MIN_LONG  = 64,
  parameter int HDR_BYTES = 4,
  parameter int VLAN_POS  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_pad,
  input  logic             cfg_crc_en,
  input  logic             cfg_hdr_en,
  input  logic             cfg_huge_en,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_abort,
  output logic             stat_valid,
  output logic [LEN_W-1:0] stat_len,
  output logic             stat_crc_err,
  output logic             stat_abort,
  output logic             stat_vlan
);

  localparam logic [LEN_W-1:0] TGT_SHORT = LEN_W'(MIN_SHORT);
  localparam logic [LEN_W-1:0] TGT_LONG  = LEN_W'(MIN_LONG);
  localparam int               FCS_BYTES = 4;
  localparam int               FCS_KW    = $clog2(FCS_BYTES);

  tx_state_e        st_q, st_d;
  logic [LEN_W-1:0] tgt_q, tgt_d, target;
  logic [FCS_KW-1:0] fcs_k_q;
  logic             free, in_fire, first, step, pad_step, fcs_step;
  logic             is_hdr, vlan_now, over, pad_on, need_pad, crc_ok;
  logic [LEN_W-1:0] body_after, body_q;
  logic [31:0]      crc_q, crc_nxt, fcs_word;
  logic [7:0]       fcs_byte;
  logic             ld, ld_sof, ld_eof, ld_abort, pend_set;
  logic [7:0]       ld_data;
  logic             p_vlan_q, p_abort_q, p_err_q;
  logic [LEN_W-1:0] out_cnt_q;
  logic             out_fire;

  // ---------------- handshake and step decode ----------------
  assign in_ready = (st_q == ST_DROP) || (((st_q == ST_IDLE) || (st_q == ST_DATA)) && free);
  assign in_fire  = in_valid && in_ready;
  assign first    = in_fire && (st_q == ST_IDLE) && in_sof;
  assign step     = first || (in_fire && (st_q == ST_DATA));
  assign pad_step = (st_q == ST_PAD) && free;
  assign fcs_step = (st_q == ST_FCS) && free;
  assign out_fire = out_valid && out_ready;

  // ---------------- sub-blocks ----------------
  eth_tx_track #(
    .LEN_W    (LEN_W),
    .HDR_BYTES(HDR_BYTES),
    .VLAN_POS (VLAN_POS)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .first     (first),
    .step      (step),
    .pad_step  (pad_step),
    .din       (in_data),
    .hdr_en    (cfg_hdr_en),
    .is_hdr    (is_hdr),
    .body_after(body_after),
    .body_q    (body_q),
    .vlan_now  (vlan_now)
  );

  eth_tx_crc32 u_crc (
    .clk    (clk),
    .rst    (rst),
    .clr    (first),
    .en     ((step && !is_hdr) || pad_step),
    .din    (pad_step ? 8'h00 : in_data),
    .crc_q  (crc_q),
    .crc_nxt(crc_nxt)
  );

  eth_tx_outreg u_oreg (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .ld_data  (ld_data),
    .ld_sof   (ld_sof),
    .ld_eof   (ld_eof),
    .ld_abort (ld_abort),
    .out_ready(out_ready),
    .free     (free),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sof  (out_sof),
    .out_eof  (out_eof),
    .out_abort(out_abort)
  );

  // ---------------- frame decisions ----------------
  always_comb begin
    over     = !cfg_huge_en && !is_hdr && (body_after > cfg_max_len);
    pad_on   = cfg_pad[0] && cfg_crc_en;
    target   = (cfg_pad[1] || (cfg_pad[2] && vlan_now)) ? TGT_LONG : TGT_SHORT;
    need_pad = pad_on && (body_after < target);
    crc_ok   = (is_hdr ? crc_q : crc_nxt) == CRC_RESIDUE;
    fcs_word = ~crc_q;
    fcs_byte = fcs_word[fcs_k_q*8 +: 8];
  end

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    ld       = 1'b0;
    ld_data  = in_data;
    ld_sof   = 1'b0;
    ld_eof   = 1'b0;
    ld_abort = 1'b0;
    pend_set = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DATA: begin
        if (step) begin
          ld     = 1'b1;
          ld_sof = first;
          st_d   = ST_DATA;
          if (over) begin
            ld_eof   = 1'b1;
            ld_abort = 1'b1;
            pend_set = 1'b1;
            st_d     = in_eof ? ST_IDLE : ST_DROP;
          end else if (in_eof) begin
            pend_set = 1'b1;
            if (need_pad) begin
              st_d  = ST_PAD;
              tgt_d = target;
            end else if (cfg_crc_en) begin
              st_d = ST_FCS;
            end else begin
              ld_eof = 1'b1;
              st_d   = ST_IDLE;
            end
          end
        end
      end
      ST_PAD: begin
        if (free) begin
          ld      = 1'b1;
          ld_data = 8'h00;
          if (body_q + LEN_W'(1) >= tgt_q) st_d = ST_FCS;
        end
      end
      ST_FCS: begin
        if (free) begin
          ld      = 1'b1;
          ld_data = fcs_byte;
          if (fcs_k_q == FCS_KW'(FCS_BYTES - 1)) begin
            ld_eof = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_DROP: begin
        if (in_fire && in_eof) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tgt_q   <= TGT_SHORT;
      fcs_k_q <= '0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      if (fcs_step) fcs_k_q <= fcs_k_q + FCS_KW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vlan_q  <= 1'b0;
      p_abort_q <= 1'b0;
      p_err_q   <= 1'b0;
    end else if (pend_set) begin
      p_vlan_q  <= vlan_now;
      p_abort_q <= over;
      p_err_q   <= !over && !cfg_crc_en && !crc_ok;
    end
  end

  // ---------------- status word ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt_q    <= '0;
      stat_valid   <= 1'b0;
      stat_len     <= '0;
      stat_crc_err <= 1'b0;
      stat_abort   <= 1'b0;
      stat_vlan    <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      if (out_fire) begin
        if (out_eof) begin
          out_cnt_q    <= '0;
          stat_valid   <= 1'b1;
          stat_len     <= out_cnt_q + LEN_W'(1);
          stat_crc_err <= p_err_q;
          stat_abort   <= p_abort_q;
          stat_vlan    <= p_vlan_q;
        end else begin
          out_cnt_q <= out_cnt_q + LEN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/eth_tx_padfcs_chk.sv
module eth_tx_padfcs_chk #(
  parameter int LEN_W     = 16,
  parameter int MIN_SHORT = 60,
  parameter int MIN_LONG  = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cfg_pad,
  input logic             cfg_crc_en,
  input logic             cfg_hdr_en,
  input logic             cfg_huge_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic             stat_valid,
  input logic [LEN_W-1:0] stat_len,
  input logic             stat_crc_err,
  input logic             stat_abort
);

  localparam logic [LEN_W-1:0] FLOOR_S = LEN_W'(MIN_SHORT + 4);
  localparam logic [LEN_W-1:0] FLOOR_L = LEN_W'(MIN_LONG + 4);

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  // R11
  stat_follows_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eof) |=> stat_valid);

  // R11
  stat_only_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(out_valid && out_ready && out_eof));

  // R7
  crc_flag_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && cfg_crc_en) |-> !stat_crc_err);

  // R3
  min_short_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && cfg_crc_en && cfg_pad[0] && !cfg_hdr_en && !stat_abort) |-> (stat_len >= FLOOR_S));

  // R2
  min_long_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && cfg_crc_en && cfg_pad[0] && cfg_pad[1] && !cfg_hdr_en && !stat_abort) |-> (stat_len >= FLOOR_L));

  // R9
  huge_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && cfg_huge_en) |-> !stat_abort);

endmodule

bind eth_tx_padfcs eth_tx_padfcs_chk #(
  .LEN_W    (LEN_W),
  .MIN_SHORT(MIN_SHORT),
  .MIN_LONG (MIN_LONG)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_pad     (cfg_pad),
  .cfg_crc_en  (cfg_crc_en),
  .cfg_hdr_en  (cfg_hdr_en),
  .cfg_huge_en (cfg_huge_en),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sof     (out_sof),
  .out_eof     (out_eof),
  .stat_valid  (stat_valid),
  .stat_len    (stat_len),
  .stat_crc_err(stat_crc_err),
  .stat_abort  (stat_abort)
);

// File: tb/eth_tx_padfcs_tb.sv
module eth_tx_padfcs_tb;

  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       cfg_pad = 3'b001;
  logic             cfg_crc_en = 1'b1, cfg_hdr_en = 1'b0, cfg_huge_en = 1'b0;
  logic [LEN_W-1:0] cfg_max_len = 16'd1518;
  logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]       in_data = 8'h00;
  logic             in_ready;
  logic             out_valid, out_sof, out_eof, out_abort;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic             stat_valid, stat_crc_err, stat_abort, stat_vlan;
  logic [LEN_W-1:0] stat_len;

  always #4 clk = ~clk;  // 125 MHz

  eth_tx_padfcs u_dut (
    .clk(clk), .rst(rst),
    .cfg_pad(cfg_pad), .cfg_crc_en(cfg_crc_en), .cfg_hdr_en(cfg_hdr_en),
    .cfg_huge_en(cfg_huge_en), .cfg_max_len(cfg_max_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort),
    .stat_valid(stat_valid), .stat_len(stat_len), .stat_crc_err(stat_crc_err),
    .stat_abort(stat_abort), .stat_vlan(stat_vlan)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  logic [7:0]  frm[$];
  logic [7:0]  cbuf[$];
  logic [10:0] exp_q[$];   // {abort, sof, eof, data}
  int          exp_len;
  logic        exp_err, exp_abort, exp_vlan;
  bit          stat_seen = 0;
  bit          stress = 1;
  bit          done = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_fcs();
    logic [31:0] c = 32'hFFFF_FFFF;
    logic        fb;
    foreach (cbuf[i]) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ cbuf[i][j];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic fill(input int n, input int seed);
    frm.delete();
    for (int i = 0; i < n; i++) frm.push_back(8'((i * 7 + seed * 13 + 5) & 255));
  endtask

  task automatic add_fcs(input int hoff);
    logic [31:0] f;
    cbuf.delete();
    for (int i = hoff; i < frm.size(); i++) cbuf.push_back(frm[i]);
    f = ref_fcs();
    for (int k = 0; k < 4; k++) frm.push_back(f[8*k +: 8]);
  endtask

  // behavioural reference for one frame
  task automatic predict();
    int          hoff, n, blen, nout, tgt;
    logic [7:0]  ob[$];
    logic [31:0] f;
    logic [31:0] got;
    bit          ab;
    hoff = cfg_hdr_en ? 4 : 0;
    n    = frm.size();
    blen = n - hoff;
    ab   = !cfg_huge_en && (blen > int'(cfg_max_len));
    nout = ab ? hoff + int'(cfg_max_len) + 1 : n;
    ob.delete();
    for (int i = 0; i < nout; i++) ob.push_back(frm[i]);
    exp_vlan  = (hoff + 13 < nout) && frm[hoff+12] == 8'h81 && frm[hoff+13] == 8'h00;
    exp_abort = ab;
    exp_err   = 0;
    if (!ab && cfg_crc_en) begin
      tgt = (cfg_pad[1] || (cfg_pad[2] && exp_vlan)) ? 64 : 60;
      if (cfg_pad[0]) while (ob.size() - hoff < tgt) ob.push_back(8'h00);
      cbuf.delete();
      for (int i = hoff; i < ob.size(); i++) cbuf.push_back(ob[i]);
      f = ref_fcs();
      for (int k = 0; k < 4; k++) ob.push_back(f[8*k +: 8]);
    end else if (!ab) begin
      cbuf.delete();
      for (int i = hoff; i < n - 4; i++) cbuf.push_back(frm[i]);
      got = {frm[n-1], frm[n-2], frm[n-3], frm[n-4]};
      exp_err = (blen < 4) || (ref_fcs() != got);
    end
    exp_len = ob.size();
    foreach (ob[i])
      exp_q.push_back({ab && (i == ob.size() - 1), i == 0, i == ob.size() - 1, ob[i]});
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_frame(input string tag, input bit chk_stall);
    cur_tag = tag;
    predict();
    stat_seen = 0;
    foreach (frm[i]) send_byte(frm[i], i == 0, i == frm.size() - 1);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    #1;
    if (chk_stall) check(in_ready == 1'b0, "R10", "in_ready during pad", in_ready, 0);
    while (!stat_seen) @(negedge clk);
    check(exp_q.size() == 0, tag, "leftover expected bytes", exp_q.size(), 0);
  endtask

  // output monitor, status checker and watchdog
  initial begin
    int          cyc;
    bit          stat_due;
    logic [10:0] got, want;
    cyc = 0;
    stat_due = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      out_ready = stress ? (($urandom & 3) != 0) : 1'b1;
      #1;
      if (!rst && !done) begin
        // R11 status timing and content
        if (stat_due) begin
          check(stat_valid == 1'b1, "R11", "stat_valid after eof", stat_valid, 1);
          check(int'(stat_len) == exp_len, "R11", "stat_len", stat_len, exp_len);
          check(stat_crc_err == exp_err, "R7", "stat_crc_err", stat_crc_err, exp_err);
          check(stat_abort == exp_abort, "R9", "stat_abort", stat_abort, exp_abort);
          check(stat_vlan == exp_vlan, "R4", "stat_vlan", stat_vlan, exp_vlan);
          stat_seen = 1;
        end else if (stat_valid) begin
          check(0, "R11", "unexpected stat_valid", 1, 0);
        end
        stat_due = 0;
        if (out_valid && out_ready) begin
          got = {out_abort, out_sof, out_eof, out_data};
          if (exp_q.size() == 0) begin
            check(0, "R10", "unexpected output byte", got, 0);
          end else begin
            want = exp_q.pop_front();
            check(got == want, cur_tag, "output byte {abort,sof,eof,data}", got, want);
          end
          if (out_eof) stat_due = 1;
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(stat_valid == 1'b0, "R1", "stat_valid after reset", stat_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R3 / R6 pad to 60, FCS appended, in_ready low while padding (R10)
    cfg_pad = 3'b001; fill(20, 1); run_frame("R3", 1);
    fill(1, 2);  run_frame("R3", 0);
    fill(60, 3); run_frame("R3", 0);
    fill(61, 4); run_frame("R6", 0);
    // R2 pad to 64
    cfg_pad = 3'b011; fill(20, 5); run_frame("R2", 0);
    cfg_pad = 3'b111; fill(40, 6); run_frame("R2", 0);
    // R4 type-dependent target
    cfg_pad = 3'b101; fill(30, 7); frm[12] = 8'h08; frm[13] = 8'h00; run_frame("R4", 0);
    fill(20, 8); frm[12] = 8'h81; frm[13] = 8'h00; run_frame("R4", 0);
    fill(20, 9); frm[12] = 8'h81; frm[13] = 8'h01; run_frame("R4", 0);
    // R5 no padding for even codes
    cfg_pad = 3'b000; fill(20, 10); run_frame("R5", 0);
    cfg_pad = 3'b110; fill(20, 11); run_frame("R5", 0);
    // R7 CRC disabled: no pad, last four bytes checked
    cfg_pad = 3'b001; cfg_crc_en = 1'b0;
    fill(26, 12); add_fcs(0); run_frame("R7", 0);
    fill(26, 13); add_fcs(0); frm[5] = frm[5] ^ 8'h10; run_frame("R7", 0);
    // R8 header excluded
    cfg_hdr_en = 1'b1;
    fill(30, 14); add_fcs(4); run_frame("R8", 0);
    cfg_crc_en = 1'b1;
    fill(24, 15); run_frame("R8", 0);
    cfg_hdr_en = 1'b0;
    // R9 length limit
    cfg_max_len = 16'd70;
    fill(71, 16); run_frame("R9", 0);
    fill(90, 17); run_frame("R9", 0);
    fill(70, 18); run_frame("R9", 0);
    cfg_huge_en = 1'b1;
    fill(100, 19); run_frame("R9", 0);
    cfg_huge_en = 1'b0; cfg_max_len = 16'd1518;
    // R10 stray bytes between frames are discarded
    cur_tag = "R10";
    for (int i = 0; i < 5; i++) send_byte(8'(i + 8'hA0), 1'b0, i == 4);
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R10", "no output from stray bytes", exp_q.size(), 0);
    fill(20, 20); run_frame("R10", 0);
    // R1 without backpressure
    stress = 0;
    fill(64, 21); run_frame("R1", 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule